// File: doc/BRIEF.md
# Interrupt Vector and Reset Entry Controller

This block decides where a small 8-bit microcontroller core fetches next when execution must be redirected. After reset it emits a single start address chosen by the power source: one address when the part runs from its battery and another when it runs from the field supply, with field-supply emulation turned off. Once the core has taken that start address, the block arbitrates five level-sensitive interrupt request lines. It hands the winning line's vector address to the fetch unit and acknowledges the winning line when the fetch unit accepts it.

Lines 1 to 4 each have an enable bit, written through a small configuration port. Line 0 is non-maskable. A separate flag, raised while privileged system code runs, keeps every line from being taken, and that includes line 0. A request that stays asserted through such a window is taken once the flag drops.

The vector leaves on a valid/ready pair. Once `vec_valid` is high, `vec_addr` does not change and the vector is not withdrawn until the fetch unit raises `vec_ready`. Back-pressure can last any number of cycles. Requests that change while the vector waits do not affect it. Arbitration resumes only after the handshake.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, `vec_valid` and `irq_ack` are 0 and `cfg_rdata` reads 5'b00001, so lines 1 to 4 are disabled.
- R2: On the first rising clock edge after reset is released, `vec_valid` goes high with `vec_addr` = 0x0000 if `pwr_batt` is 1, or 0x0010 if `pwr_batt` is 0. This start vector raises no `irq_ack`, and no interrupt vector is issued until the fetch unit has accepted it.
- R3: A clock edge with `cfg_we` high loads `cfg_wdata[i]` as the enable of line i, for i = 1..4. `cfg_rdata[i]` returns that enable and `cfg_rdata[0]` always reads 1. A line whose enable is 0 is never taken.
- R4: Line 0 is taken whenever it is requested, whatever enables are written.
- R5: No interrupt vector is issued on an edge where `sys_mode` is high, and this includes line 0.
- R6: A request still asserted when `sys_mode` falls is taken on the next edge.
- R7: When several eligible lines request together, the lowest-numbered one wins.
- R8: The vector of line n is 0x0020 + 4·n.
- R9: An eligible request present at a clock edge while the block is idle makes `vec_valid` high after that edge. The vector then stays valid and unchanged until an edge with `vec_ready` high.
- R10: For an interrupt vector, `irq_ack` bit n is 1 exactly while `vec_valid` and `vec_ready` are both high. At all other times `irq_ack` is 0.
- R11: After each handshake `vec_valid` is low for at least one cycle. A request still asserted after its acknowledge is arbitrated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_batt | input | 1 | 1 = battery supply, 0 = field supply with emulation off |
| sys_mode | input | 1 | High while privileged system code runs; blocks all lines |
| irq_req | input | 5 | Level request, bit n = line n |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 4 | Enables for lines 4..1 (bit i = line i) |
| cfg_rdata | output | 5 | Effective enables, bit 0 always 1 |
| vec_valid | output | 1 | Vector address is valid |
| vec_ready | input | 1 | Fetch unit accepts the vector |
| vec_addr | output | 16 | Start or interrupt vector address |
| irq_ack | output | 5 | One-hot acknowledge in the accepting cycle |

## Verification
The bench holds line 0 high straight out of reset with the fetch unit stalled. A design that let an interrupt overtake the start vector, or acknowledged the start vector, shows the wrong address or a stray acknowledge. It raises a lower-numbered line while a vector is stalled, which catches an output that re-arbitrates under back-pressure. It also holds requests through a system-code window, line 0 included, which exposes a non-maskable path that bypasses the flag and a pending request that is lost when the flag falls. The table covers masked lines, line 0 with its enable bit written 0, and mixed request patterns where a wrong priority order selects the wrong vector.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_HOLD = 2'd2
  } vst_t;
endpackage

// File: rtl/irq_en_regs.sv
module irq_en_regs #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [NSRC-1:1] cfg_wdata,
  output logic [NSRC-1:0] en_eff
);
  logic [NSRC-1:1] en_q;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
      if (i == 0) begin : g_nmi
        assign en_eff[i] = 1'b1;
      end else begin : g_mask
        always_ff @(posedge clk) begin
          if (!rst_n)      en_q[i] <= 1'b0;
          else if (cfg_we) en_q[i] <= cfg_wdata[i];
        end
        assign en_eff[i] = en_q[i];
      end
    end
  endgenerate

  // enables only move on a write strobe
  assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(en_q));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 5,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] elig,
  output logic            pick_any,
  output logic [IW-1:0]   pick_idx
);
  always_comb begin
    pick_any = |elig;
    pick_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) pick_idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_vec_stage.sv
module irq_vec_stage import irq_entry_pkg::*; #(
  parameter int             NSRC      = 5,
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  BOOT_BATT = 16'h0000,
  parameter logic [AW-1:0]  BOOT_XPDR = 16'h0010,
  parameter logic [AW-1:0]  VEC_BASE  = 16'h0020,
  parameter logic [AW-1:0]  VEC_STEP  = 16'h0004,
  localparam int IW = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_batt,
  input  logic          pick_any,
  input  logic [IW-1:0] pick_idx,
  input  logic          vec_ready,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic          vec_is_boot,
  output logic [IW-1:0] vec_src
);
  vst_t st;
  logic [AW-1:0] irq_addr;

  assign irq_addr = VEC_BASE + AW'(pick_idx) * VEC_STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_BOOT;
      vec_valid   <= 1'b0;
      vec_addr    <= '0;
      vec_is_boot <= 1'b0;
      vec_src     <= '0;
    end else begin
      case (st)
        ST_BOOT: begin
          vec_valid   <= 1'b1;
          vec_is_boot <= 1'b1;
          vec_addr    <= pwr_batt ? BOOT_BATT : BOOT_XPDR;
          st          <= ST_HOLD;
        end
        ST_IDLE: begin
          if (pick_any) begin
            vec_valid   <= 1'b1;
            vec_is_boot <= 1'b0;
            vec_src     <= pick_idx;
            vec_addr    <= irq_addr;
            st          <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (vec_ready) begin
            vec_valid   <= 1'b0;
            vec_is_boot <= 1'b0;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_vec_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr));

  assert_gap_after_hs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> !vec_valid);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int             NSRC      = 5,
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  BOOT_BATT = 16'h0000,
  parameter logic [AW-1:0]  BOOT_XPDR = 16'h0010,
  parameter logic [AW-1:0]  VEC_BASE  = 16'h0020,
  parameter logic [AW-1:0]  VEC_STEP  = 16'h0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_batt,
  input  logic            sys_mode,
  input  logic [NSRC-1:0] irq_req,
  input  logic            cfg_we,
  input  logic [NSRC-1:1] cfg_wdata,
  output logic [NSRC-1:0] cfg_rdata,
  output logic            vec_valid,
  input  logic            vec_ready,
  output logic [AW-1:0]   vec_addr,
  output logic [NSRC-1:0] irq_ack
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] en_eff;
  logic [NSRC-1:0] elig;
  logic            pick_any;
  logic [IW-1:0]   pick_idx;
  logic            vec_is_boot;
  logic [IW-1:0]   vec_src;
  logic            hs_irq;

  irq_en_regs #(.NSRC(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .en_eff(en_eff)
  );

  assign cfg_rdata = en_eff;
  assign elig      = irq_req & en_eff & {NSRC{~sys_mode}};

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .elig(elig), .pick_any(pick_any), .pick_idx(pick_idx)
  );

  irq_vec_stage #(
    .NSRC(NSRC), .AW(AW), .BOOT_BATT(BOOT_BATT), .BOOT_XPDR(BOOT_XPDR),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_vec (
    .clk(clk), .rst_n(rst_n), .pwr_batt(pwr_batt),
    .pick_any(pick_any), .pick_idx(pick_idx), .vec_ready(vec_ready),
    .vec_valid(vec_valid), .vec_addr(vec_addr),
    .vec_is_boot(vec_is_boot), .vec_src(vec_src)
  );

  assign hs_irq = vec_valid & vec_ready & ~vec_is_boot;

  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_ack
      assign irq_ack[n] = hs_irq & (vec_src == IW'(n));
    end
  endgenerate

  assert_sys_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) && !vec_is_boot |-> !$past(sys_mode));

  assert_taken_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) && !vec_is_boot |->
      ($past(irq_req & en_eff) & (NSRC'(1) << vec_src)) != '0);

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) && !vec_is_boot |->
      ($past(elig) & ((NSRC'(1) << vec_src) - NSRC'(1))) == '0);
endmodule

// File: tb/tb_irq_entry_ctrl.sv
module tb_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_batt = 1'b1;
  logic        sys_mode = 1'b0;
  logic [4:0]  irq_req = '0;
  logic        cfg_we = 1'b0;
  logic [4:1]  cfg_wdata = '0;
  logic [4:0]  cfg_rdata;
  logic        vec_valid;
  logic        vec_ready = 1'b1;
  logic [15:0] vec_addr;
  logic [4:0]  irq_ack;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pwr_batt(pwr_batt), .sys_mode(sys_mode),
    .irq_req(irq_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_addr(vec_addr), .irq_ack(irq_ack)
  );

  // {en[4:0], req[4:0], sys, take, src[2:0]}
  localparam int NT = 10;
  localparam logic [14:0] TBL [NT] = '{
    {5'b11110, 5'b00001, 1'b0, 1'b1, 3'd0},  // R4
    {5'b00000, 5'b00001, 1'b0, 1'b1, 3'd0},  // R4
    {5'b00000, 5'b11110, 1'b0, 1'b0, 3'd0},  // R3
    {5'b11110, 5'b11110, 1'b0, 1'b1, 3'd1},  // R7
    {5'b10100, 5'b11010, 1'b0, 1'b1, 3'd4},  // R3
    {5'b11110, 5'b11111, 1'b1, 1'b0, 3'd0},  // R5
    {5'b01000, 5'b01100, 1'b0, 1'b1, 3'd3},  // R3
    {5'b11110, 5'b10100, 1'b0, 1'b1, 3'd2},  // R7
    {5'b11110, 5'b00000, 1'b0, 1'b0, 3'd0},  // R9
    {5'b00110, 5'b11111, 1'b0, 1'b1, 3'd0}   // R7
  };

  function automatic logic [15:0] vaddr(input int s);
    return 16'(16'h0020 + 4 * s);  // R8
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_en(input logic [4:0] en);
    cfg_we = 1'b1; cfg_wdata = en[4:1];
    tick();
    cfg_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
    end
  end

  initial begin
    // R1 / R2: battery start vector
    rst_n = 1'b0; pwr_batt = 1'b1; vec_ready = 1'b1;
    repeat (3) tick();
    check(vec_valid == 1'b0, "R1 valid in reset", 32'(vec_valid), 0);
    check(irq_ack == '0, "R1 ack in reset", 32'(irq_ack), 0);
    check(cfg_rdata == 5'b00001, "R1 enables in reset", 32'(cfg_rdata), 1);
    rst_n = 1'b1;
    tick();
    check(vec_valid && vec_addr == 16'h0000, "R2 battery start", 32'(vec_addr), 0);
    check(irq_ack == '0, "R2 no ack on start", 32'(irq_ack), 0);
    tick();
    check(vec_valid == 1'b0, "R11 gap after start", 32'(vec_valid), 0);

    // R3..R9 table walk
    for (int k = 0; k < NT; k++) begin
      logic [14:0] e;
      e = TBL[k];
      write_en(e[14:10]);
      check(cfg_rdata == {e[14:11], 1'b1}, "R3 readback", 32'(cfg_rdata),
            32'({e[14:11], 1'b1}));
      irq_req = e[9:5]; sys_mode = e[4];
      tick();
      if (e[3]) begin
        check(vec_valid && vec_addr == vaddr(int'(e[2:0])), "R8 table vector",
              32'(vec_addr), 32'(vaddr(int'(e[2:0]))));
        check(irq_ack == (5'b00001 << e[2:0]), "R10 table ack", 32'(irq_ack),
              32'(5'b00001 << e[2:0]));
      end else begin
        check(vec_valid == 1'b0, "R5 table no vector", 32'(vec_valid), 0);
      end
      irq_req = '0; sys_mode = 1'b0;
      tick();
      tick();
      check(vec_valid == 1'b0, "R11 table idle", 32'(vec_valid), 0);
    end

    // R2: transponder start, line 0 held, fetch stalled
    rst_n = 1'b0; pwr_batt = 1'b0; vec_ready = 1'b0; irq_req = 5'b00001;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    for (int j = 0; j < 3; j++) begin
      check(vec_valid && vec_addr == 16'h0010, "R2 field start held",
            32'(vec_addr), 32'h10);
      tick();
    end
    vec_ready = 1'b1;
    #0.5;
    check(irq_ack == '0, "R2 start not acked", 32'(irq_ack), 0);
    tick();
    check(vec_valid == 1'b0, "R11 gap", 32'(vec_valid), 0);
    tick();
    check(vec_valid && vec_addr == vaddr(0), "R4 line0 after start",
          32'(vec_addr), 32'(vaddr(0)));
    irq_req = '0;
    tick(); tick();

    // R9: back-pressure
    write_en(5'b11110);
    vec_ready = 1'b0; irq_req = 5'b00100;
    tick();
    check(vec_valid && vec_addr == vaddr(2), "R9 stall vector", 32'(vec_addr),
          32'(vaddr(2)));
    check(irq_ack == '0, "R10 no ack while stalled", 32'(irq_ack), 0);
    irq_req = 5'b00001;
    tick();
    check(vec_valid && vec_addr == vaddr(2), "R9 stable under stall",
          32'(vec_addr), 32'(vaddr(2)));
    irq_req = '0; vec_ready = 1'b1;
    #0.5;
    check(irq_ack == 5'b00100, "R10 ack on accept", 32'(irq_ack), 32'h4);
    tick();
    check(vec_valid == 1'b0, "R11 cleared after accept", 32'(vec_valid), 0);
    tick();

    // R5 / R6: held through system code
    sys_mode = 1'b1; irq_req = 5'b00011;
    for (int j = 0; j < 3; j++) begin
      tick();
      check(vec_valid == 1'b0, "R5 blocked incl line0", 32'(vec_valid), 0);
    end
    sys_mode = 1'b0;
    tick();
    check(vec_valid && vec_addr == vaddr(0), "R6 serviced after flag",
          32'(vec_addr), 32'(vaddr(0)));
    irq_req = 5'b00010;
    tick();
    tick();
    check(vec_valid && vec_addr == vaddr(1), "R11 re-arbitrated",
          32'(vec_addr), 32'(vaddr(1)));
    check(irq_ack == 5'b00010, "R10 second ack", 32'(irq_ack), 32'h2);
    irq_req = '0;
    tick(); tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule